// File: doc/BRIEF.md
# Compare and Set-Flag Unit

This block evaluates the compare instructions of a 32-bit core. Each compare names a relation and a signedness and uses operand A together with either operand B or a 16-bit immediate. The result is written to a single condition flag and to nothing else. That flag is a status bit that persists from one instruction to the next. It holds its value until a later compare overwrites it.

The stored flag drives two consumers. The first is a branch-taken signal that serves both branch forms, branch-when-set and branch-when-clear. The second is a conditional-move select that forwards operand A when the flag is set and operand B when it is clear. The immediate is always sign-extended to the operand width, and this holds for unsigned compares too.

Top module: `cmpflag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the flag is cleared to 0.
- R2: The flag is written on the rising edge at which `cmp_valid` is high. At every other edge it keeps its previous value, whatever the operand inputs are.
- R3: The relation code on `rel_code` is decoded as 0 = equal, 1 = not equal, 2 = greater than, 3 = greater or equal, 4 = less than and 5 = less or equal. The flag becomes 1 exactly when A stands in that relation to the second operand.
- R4: With `is_unsigned` = 1 the ordering relations (codes 2 to 5) compare the operands as unsigned magnitudes. With 0 they compare them as two's complement numbers. Codes 0 and 1 give the same result either way.
- R5: With `use_imm` = 1 the second operand is `imm` sign-extended from its top bit to the operand width, and this also applies to unsigned compares. With 0 the second operand is `opb`.
- R6: A valid compare whose relation code is 6 or 7 leaves the flag unchanged.
- R7: `branch_taken` equals `br_req` AND flag when `br_on_set` = 1, and `br_req` AND NOT flag when `br_on_set` = 0.
- R8: `cmov_result` equals `opa` while the flag is 1 and `opb` while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare strobe; the flag is written at this edge |
| rel_code | input | 3 | Relation code (see R3) |
| is_unsigned | input | 1 | 1 selects an unsigned ordering |
| use_imm | input | 1 | 1 selects the immediate as the second operand |
| opa | input | DATA_W | Operand A; conditional-move source when the flag is set |
| opb | input | DATA_W | Operand B; conditional-move source when the flag is clear |
| imm | input | IMM_W | Immediate field, sign-extended before use |
| br_req | input | 1 | A conditional branch is being resolved |
| br_on_set | input | 1 | 1 selects branch-when-set, 0 selects branch-when-clear |
| flag | output | 1 | Stored condition flag |
| branch_taken | output | 1 | Branch decision derived from the flag |
| cmov_result | output | DATA_W | Conditional-move result |

## Verification
The bench builds the block with its default widths, DATA_W = 32 and IMM_W = 16. At these widths the signed and unsigned orderings disagree at the 0x80000000 boundary and for operands of all ones, and the bench uses both cases. The same widths also make bit 15 of the immediate the sign bit. This exposes the difference between sign extension and zero extension: an unsigned compare of 0x00010000 against immediate 0xFFFF gives opposite results under the two extensions.

// File: rtl/cmpflag_pkg.sv
`timescale 1ns/1ps
package cmpflag_pkg;

    typedef enum logic [2:0] {
        REL_EQ  = 3'd0,
        REL_NE  = 3'd1,
        REL_GT  = 3'd2,
        REL_GE  = 3'd3,
        REL_LT  = 3'd4,
        REL_LE  = 3'd5,
        REL_RS6 = 3'd6,
        REL_RS7 = 3'd7
    } rel_e;

    typedef struct packed {
        logic eq;
        logic lt;
    } cmp_prim_t;

    // Maps the primitive results onto the requested relation.
    function automatic logic rel_apply(input rel_e r, input cmp_prim_t p);
        case (r)
            REL_EQ:  return p.eq;
            REL_NE:  return !p.eq;
            REL_GT:  return !(p.lt || p.eq);
            REL_GE:  return !p.lt;
            REL_LT:  return p.lt;
            REL_LE:  return p.lt || p.eq;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic rel_legal(input rel_e r);
        return (r != REL_RS6) && (r != REL_RS7);
    endfunction

endpackage

// File: rtl/cmpflag_opsel.sv
`timescale 1ns/1ps
module cmpflag_opsel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] b_eff
);
    localparam int EXT_W = (DATA_W > IMM_W) ? DATA_W - IMM_W : 1;

    logic [DATA_W-1:0] imm_ext;

    generate
        if (DATA_W > IMM_W) begin : g_extend
            logic [EXT_W-1:0] fill;
            assign fill    = {EXT_W{imm[IMM_W-1]}};
            assign imm_ext = {fill, imm};
        end else begin : g_trunc
            assign imm_ext = imm[DATA_W-1:0];
        end
    endgenerate

    assign b_eff = use_imm ? imm_ext : opb;
endmodule

// File: rtl/cmpflag_eval.sv
`timescale 1ns/1ps
module cmpflag_eval
    import cmpflag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_unsigned,
    input  rel_e              rel,
    output logic              result,
    output logic              legal
);
    cmp_prim_t prim;

    always_comb begin
        prim.eq = (a == b);
        if (is_unsigned) begin
            prim.lt = (a < b);
        end else begin
            prim.lt = ($signed(a) < $signed(b));
        end
        result = rel_apply(rel, prim);
        legal  = rel_legal(rel);
    end
endmodule

// File: rtl/cmpflag_store.sv
`timescale 1ns/1ps
module cmpflag_store #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_val,
    input  logic              br_req,
    input  logic              br_on_set,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              flag,
    output logic              branch_taken,
    output logic [DATA_W-1:0] cmov_result
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (wr_en) begin
            flag_q <= wr_val;
        end
    end

    assign flag         = flag_q;
    assign branch_taken = br_req && (br_on_set ? flag_q : !flag_q);
    assign cmov_result  = flag_q ? opa : opb;
endmodule

// File: rtl/cmpflag_unit.sv
`timescale 1ns/1ps
module cmpflag_unit
    import cmpflag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_valid,
    input  logic [2:0]        rel_code,
    input  logic              is_unsigned,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    input  logic              br_req,
    input  logic              br_on_set,
    output logic              flag,
    output logic              branch_taken,
    output logic [DATA_W-1:0] cmov_result
);
    logic [DATA_W-1:0] b_eff;
    logic              cmp_res;
    logic              cmp_legal;
    rel_e              rel;

    assign rel = rel_e'(rel_code);

    cmpflag_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .use_imm (use_imm),
        .opb     (opb),
        .imm     (imm),
        .b_eff   (b_eff)
    );

    cmpflag_eval #(.DATA_W(DATA_W)) u_eval (
        .a           (opa),
        .b           (b_eff),
        .is_unsigned (is_unsigned),
        .rel         (rel),
        .result      (cmp_res),
        .legal       (cmp_legal)
    );

    cmpflag_store #(.DATA_W(DATA_W)) u_store (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (cmp_valid && cmp_legal),
        .wr_val       (cmp_res),
        .br_req       (br_req),
        .br_on_set    (br_on_set),
        .opa          (opa),
        .opb          (opb),
        .flag         (flag),
        .branch_taken (branch_taken),
        .cmov_result  (cmov_result)
    );
endmodule

// File: rtl/cmpflag_unit_chk.sv
`timescale 1ns/1ps
module cmpflag_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cmp_valid,
    input logic [2:0]        rel_code,
    input logic              use_imm,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic              br_req,
    input logic              br_on_set,
    input logic              flag,
    input logic              branch_taken,
    input logic [DATA_W-1:0] cmov_result
);
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !cmp_valid |=> $stable(flag));

    assert_eq_reg_R3: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && rel_code == 3'd0 && !use_imm) |=> (flag == $past(opa == opb)));

    assert_ne_reg_R3: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && rel_code == 3'd1 && !use_imm) |=> (flag == $past(opa != opb)));

    assert_bad_code_R6: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && rel_code[2] && rel_code[1]) |=> $stable(flag));

    assert_branch_set_R7: assert property (@(posedge clk) disable iff (rst)
        (br_req && br_on_set) |-> (branch_taken == flag));

    assert_branch_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !br_req |-> !branch_taken);

    assert_cmov_a_R8: assert property (@(posedge clk) disable iff (rst)
        flag |-> (cmov_result == opa));

    assert_cmov_b_R8: assert property (@(posedge clk) disable iff (rst)
        !flag |-> (cmov_result == opb));
endmodule

bind cmpflag_unit cmpflag_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmp_valid    (cmp_valid),
    .rel_code     (rel_code),
    .use_imm      (use_imm),
    .opa          (opa),
    .opb          (opb),
    .br_req       (br_req),
    .br_on_set    (br_on_set),
    .flag         (flag),
    .branch_taken (branch_taken),
    .cmov_result  (cmov_result)
);

// File: tb/cmpflag_unit_tb.sv
`timescale 1ns/1ps
module cmpflag_unit_tb;
    localparam int DW = 32;
    localparam int IW = 16;
    localparam int NV = 16;
    localparam int VW = 3 + 1 + 1 + DW + DW + IW + 1;

    // {rel, unsigned, use_imm, a, b, imm, expected flag}
    localparam logic [VW-1:0] VEC [NV] = '{
        {3'd0, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0005, 16'h0000, 1'b1},
        {3'd1, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0005, 16'h0000, 1'b0},
        {3'd2, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0},
        {3'd2, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b1},
        {3'd4, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b1},
        {3'd4, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0},
        {3'd3, 1'b0, 1'b0, 32'h0000_0007, 32'h0000_0007, 16'h0000, 1'b1},
        {3'd5, 1'b1, 1'b0, 32'h0000_0008, 32'h0000_0007, 16'h0000, 1'b0},
        {3'd5, 1'b0, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0000, 1'b1},
        {3'd2, 1'b1, 1'b1, 32'h0000_0001, 32'h0000_0000, 16'hFFFF, 1'b0},
        {3'd4, 1'b1, 1'b1, 32'h0001_0000, 32'h0000_0000, 16'hFFFF, 1'b1},
        {3'd3, 1'b0, 1'b1, 32'hFFFF_FFFE, 32'h0000_0000, 16'hFFFE, 1'b1},
        {3'd0, 1'b0, 1'b1, 32'hFFFF_8000, 32'h0000_0000, 16'h8000, 1'b1},
        {3'd1, 1'b1, 1'b1, 32'h0000_8000, 32'h0000_0000, 16'h8000, 1'b1},
        {3'd2, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000, 16'h7FFF, 1'b0},
        {3'd3, 1'b1, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 16'h0000, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmp_valid = 1'b0;
    logic [2:0]    rel_code = 3'd0;
    logic          is_unsigned = 1'b0;
    logic          use_imm = 1'b0;
    logic [DW-1:0] opa = '0;
    logic [DW-1:0] opb = '0;
    logic [IW-1:0] imm = '0;
    logic          br_req = 1'b0;
    logic          br_on_set = 1'b0;
    logic          flag;
    logic          branch_taken;
    logic [DW-1:0] cmov_result;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    cmpflag_unit #(.DATA_W(DW), .IMM_W(IW)) u_dut (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .rel_code(rel_code),
        .is_unsigned(is_unsigned), .use_imm(use_imm), .opa(opa), .opb(opb),
        .imm(imm), .br_req(br_req), .br_on_set(br_on_set), .flag(flag),
        .branch_taken(branch_taken), .cmov_result(cmov_result)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Presents a compare for one edge; returns at the following negedge.
    task automatic do_cmp(input logic [2:0] r, input logic u, input logic si,
                          input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [IW-1:0] im);
        @(negedge clk);
        rel_code = r; is_unsigned = u; use_imm = si; opa = a; opb = b; imm = im;
        cmp_valid = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset flag", {31'd0, flag}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            do_cmp(v[VW-1 -: 3], v[VW-4], v[VW-5], v[VW-6 -: DW], v[IW+DW -: DW], v[IW:1]);
            check(v[VW-5] ? "R5 R3 R4 vector flag" : "R3 R4 vector flag", {31'd0, flag}, {31'd0, v[0]});
            check("R8 cmov", cmov_result, v[0] ? v[VW-6 -: DW] : v[IW+DW -: DW]);
        end

        // R2: idle cycles with changed operands keep the flag (last vector left it 0)
        do_cmp(3'd0, 1'b0, 1'b0, 32'h1, 32'h1, 16'h0);
        check("R2 set by compare", {31'd0, flag}, 32'd1);
        @(negedge clk);
        opa = 32'h1; opb = 32'h2; rel_code = 3'd0;
        repeat (3) @(negedge clk);
        check("R2 hold while idle", {31'd0, flag}, 32'd1);
        check("R8 cmov A while set", cmov_result, 32'h1);

        // R6: illegal codes leave the flag as is
        do_cmp(3'd6, 1'b0, 1'b0, 32'h1, 32'h2, 16'h0);
        check("R6 code 6 ignored", {31'd0, flag}, 32'd1);
        do_cmp(3'd7, 1'b1, 1'b0, 32'h1, 32'h2, 16'h0);
        check("R6 code 7 ignored", {31'd0, flag}, 32'd1);

        // R7: branch decision with flag = 1
        br_req = 1'b1; br_on_set = 1'b1; #1;
        check("R7 branch-when-set, flag 1", {31'd0, branch_taken}, 32'd1);
        br_on_set = 1'b0; #1;
        check("R7 branch-when-clear, flag 1", {31'd0, branch_taken}, 32'd0);
        br_req = 1'b0; br_on_set = 1'b1; #1;
        check("R7 no request", {31'd0, branch_taken}, 32'd0);

        // flag = 0 via a not-equal on equal operands
        do_cmp(3'd1, 1'b0, 1'b0, 32'h9, 32'h9, 16'h0);
        check("R3 ne equal operands", {31'd0, flag}, 32'd0);
        check("R8 cmov B while clear", cmov_result, 32'h9);
        br_req = 1'b1; br_on_set = 1'b0; #1;
        check("R7 branch-when-clear, flag 0", {31'd0, branch_taken}, 32'd1);
        br_on_set = 1'b1; #1;
        check("R7 branch-when-set, flag 0", {31'd0, branch_taken}, 32'd0);
        br_req = 1'b0;

        // R1: reset in mid-run clears a set flag
        do_cmp(3'd3, 1'b0, 1'b0, 32'h5, 32'h5, 16'h0);
        check("R3 ge equal", {31'd0, flag}, 32'd1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset mid-run", {31'd0, flag}, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule